// File: doc/BRIEF.md
# Dual-Clock Byte-Lane Synchronous RAM

The block is a synchronous memory of 4096 words by 36 bits with two independent access ports, each on its own clock. Both ports may read or write the array in the same cycle. Every port captures its address, write data and control on the rising edge of its clock. Execution happens on the following edge of that same clock: a write is committed to the array, or the read output register loads.

The 36-bit word is split into two 18-bit halves. Each half of each port has its own select, output enable and clock-enable input, and each 9-bit byte lane has its own write strobe. A half with clock enable high keeps its captured state and starts no operation. The output enable acts without a clock on the drive-enable that marks the read data as valid for a tri-state pad ring. Storage is built from one bank per port and half. Each bank is written only by its own port and holds the written data XOR-folded with the other port's bank, so reading both banks and XORing them gives the last value written.

Top module: `dual_lane_ram`

## Requirements
- R1: While rst_ni is low, both drive-enable outputs are 0. After reset the read data outputs are 0 until a read executes.
- R2: A write captured at edge n of a port's clock is committed at edge n+1. A read of that address captured at edge n+1 returns the new data.
- R3: The write strobe wr_ni[k] (active low) writes only bits 9k to 9k+8, with lane 0 in bits 0-8 and lane 3 in bits 27-35. All other lanes of the word keep their contents.
- R4: Index 0 of cke_ni, sel_ni and oe_ni governs bits 0-17 (lanes 0 and 1). Index 1 governs bits 18-35 (lanes 2 and 3). The two halves of one port can run different operations in the same cycle.
- R5: When cke_ni[h] is 1 at an edge, that half captures nothing and starts no operation. Its read data and drive state do not change at the following edge, and a write presented in that cycle is never committed.
- R6: A half captured with sel_ni[h] = 1 is deselected, whatever its write strobes are. It changes no array contents and clears its drive flag on its execution edge.
- R7: A half captured with sel_ni[h] = 0 and any of its write strobes low is a write cycle. On execution its drive flag clears and its read data register keeps its previous value.
- R8: A half captured with sel_ni[h] = 0 and both of its write strobes high is a read. At edge n+1 its read data register loads the stored half-word and its drive flag sets.
- R9: drv_o[h] equals the half's drive flag AND NOT oe_ni[h], and it follows oe_ni with no clock edge.
- R10: A write captured on the edge right after a read (a turnaround with select held low) is committed.
- R11: Data written through one port is read through the other port once the write has executed.
- R12: Both ports can run back-to-back writes and reads to distinct addresses at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of all port registers |
| a_clk_i | input | 1 | Port A clock |
| a_cke_ni | input | 2 | Port A per-half clock enable, active low |
| a_sel_ni | input | 2 | Port A per-half select, active low |
| a_wr_ni | input | 4 | Port A per-lane write strobe, active low |
| a_oe_ni | input | 2 | Port A per-half output enable, active low, asynchronous |
| a_addr_i | input | 12 | Port A word address |
| a_wdata_i | input | 36 | Port A write data |
| a_rdata_o | output | 36 | Port A read data register |
| a_drv_o | output | 2 | Port A per-half pad drive enable |
| b_clk_i | input | 1 | Port B clock |
| b_cke_ni | input | 2 | Port B per-half clock enable, active low |
| b_sel_ni | input | 2 | Port B per-half select, active low |
| b_wr_ni | input | 4 | Port B per-lane write strobe, active low |
| b_oe_ni | input | 2 | Port B per-half output enable, active low, asynchronous |
| b_addr_i | input | 12 | Port B word address |
| b_wdata_i | input | 36 | Port B write data |
| b_rdata_o | output | 36 | Port B read data register |
| b_drv_o | output | 2 | Port B per-half pad drive enable |

## Verification
The bench first writes and reads whole words, including the lowest and highest addresses. This separates correct addressing and latency from wrong or off-by-one capture. Single-lane strobe patterns and split-half patterns follow: mixed clock enables, one half selected with the other deselected, and one half writing while the other reads. These expose any leakage between lanes or halves. Held cycles that carry write strobes, and deselects in both strobe states, show that no stray write reaches the array. Read-write-read turnarounds, cross-port write/read pairs on two phase-shifted clocks, and concurrent streams on both ports show that the XOR-folded banks return the last written value.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  localparam int NUM_PORTS      = 2;
  localparam int NUM_HALVES     = 2;
  localparam int LANES_PER_HALF = 2;
  localparam int LANES          = NUM_HALVES * LANES_PER_HALF;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_DESEL
  } op_e;
endpackage

// File: rtl/dlr_bank.sv
// One storage bank: single write port on the owner's clock, combinational reads for every port.
module dlr_bank #(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int NRD    = 2,
  localparam int W     = LANE_W * LANES,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0] raddr_i [NRD],
  output logic [W-1:0]      rdata_o [NRD]
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_i[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end
endmodule

// File: rtl/dlr_half_port.sv
// Input capture, command decode, read register and drive flag for one half of one port.
module dlr_half_port
  import dlr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int W     = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              sel_ni,
  input  logic              oe_ni,
  input  logic [LANES-1:0]  wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      mem_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [LANES-1:0]  we_o,
  output logic [W-1:0]      wdata_q_o,
  output logic [W-1:0]      rdata_o,
  output logic              drv_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [W-1:0]      wdata_q;
  logic [W-1:0]      rdata_q;
  logic [LANES-1:0]  wr_q;
  logic              sel_q;
  logic              go_q;
  logic              act_q;
  op_e               op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= '0;
      sel_q   <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      go_q <= ~cke_ni;
      if (!cke_ni) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        wr_q    <= ~wr_ni;
        sel_q   <= ~sel_ni;
      end
    end
  end

  always_comb begin
    op = OP_NONE;
    if (go_q) begin
      if (!sel_q)     op = OP_DESEL;
      else if (|wr_q) op = OP_WRITE;
      else            op = OP_READ;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      act_q   <= 1'b0;
    end else begin
      unique case (op)
        OP_READ: begin
          rdata_q <= mem_i;
          act_q   <= 1'b1;
        end
        OP_WRITE, OP_DESEL: act_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign addr_q_o  = addr_q;
  assign wdata_q_o = wdata_q;
  assign we_o      = (op == OP_WRITE) ? wr_q : '0;
  assign rdata_o   = rdata_q;
  assign drv_o     = act_q & ~oe_ni;
endmodule

// File: rtl/dual_lane_ram.sv
module dual_lane_ram
  import dlr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int LANE_W  = 9,
  localparam int HALF_W = LANE_W * LANES_PER_HALF,
  localparam int DATA_W = HALF_W * NUM_HALVES
) (
  input  logic                  rst_ni,
  input  logic                  a_clk_i,
  input  logic [NUM_HALVES-1:0] a_cke_ni,
  input  logic [NUM_HALVES-1:0] a_sel_ni,
  input  logic [LANES-1:0]      a_wr_ni,
  input  logic [NUM_HALVES-1:0] a_oe_ni,
  input  logic [ADDR_W-1:0]     a_addr_i,
  input  logic [DATA_W-1:0]     a_wdata_i,
  output logic [DATA_W-1:0]     a_rdata_o,
  output logic [NUM_HALVES-1:0] a_drv_o,
  input  logic                  b_clk_i,
  input  logic [NUM_HALVES-1:0] b_cke_ni,
  input  logic [NUM_HALVES-1:0] b_sel_ni,
  input  logic [LANES-1:0]      b_wr_ni,
  input  logic [NUM_HALVES-1:0] b_oe_ni,
  input  logic [ADDR_W-1:0]     b_addr_i,
  input  logic [DATA_W-1:0]     b_wdata_i,
  output logic [DATA_W-1:0]     b_rdata_o,
  output logic [NUM_HALVES-1:0] b_drv_o
);
  logic                      clk_v   [NUM_PORTS];
  logic [NUM_HALVES-1:0]     cke_v   [NUM_PORTS];
  logic [NUM_HALVES-1:0]     sel_v   [NUM_PORTS];
  logic [NUM_HALVES-1:0]     oe_v    [NUM_PORTS];
  logic [LANES-1:0]          wr_v    [NUM_PORTS];
  logic [ADDR_W-1:0]         addr_v  [NUM_PORTS];
  logic [DATA_W-1:0]         wdata_v [NUM_PORTS];

  logic [ADDR_W-1:0]         addr_q  [NUM_PORTS][NUM_HALVES];
  logic [LANES_PER_HALF-1:0] we      [NUM_PORTS][NUM_HALVES];
  logic [HALF_W-1:0]         wdq     [NUM_PORTS][NUM_HALVES];
  logic [HALF_W-1:0]         store   [NUM_PORTS][NUM_HALVES];
  logic [HALF_W-1:0]         mem_rd  [NUM_PORTS][NUM_HALVES];
  logic [HALF_W-1:0]         rdq     [NUM_PORTS][NUM_HALVES];
  logic                      drv_v   [NUM_PORTS][NUM_HALVES];
  logic [ADDR_W-1:0]         raddr   [NUM_HALVES][NUM_PORTS];
  // bank owner, half, reading port
  logic [HALF_W-1:0]         brd     [NUM_PORTS][NUM_HALVES][NUM_PORTS];

  assign clk_v[0]   = a_clk_i;
  assign clk_v[1]   = b_clk_i;
  assign cke_v[0]   = a_cke_ni;
  assign cke_v[1]   = b_cke_ni;
  assign sel_v[0]   = a_sel_ni;
  assign sel_v[1]   = b_sel_ni;
  assign oe_v[0]    = a_oe_ni;
  assign oe_v[1]    = b_oe_ni;
  assign wr_v[0]    = a_wr_ni;
  assign wr_v[1]    = b_wr_ni;
  assign addr_v[0]  = a_addr_i;
  assign addr_v[1]  = b_addr_i;
  assign wdata_v[0] = a_wdata_i;
  assign wdata_v[1] = b_wdata_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      dlr_half_port #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES_PER_HALF)
      ) u_port (
        .clk_i     (clk_v[p]),
        .rst_ni    (rst_ni),
        .cke_ni    (cke_v[p][h]),
        .sel_ni    (sel_v[p][h]),
        .oe_ni     (oe_v[p][h]),
        .wr_ni     (wr_v[p][h*LANES_PER_HALF +: LANES_PER_HALF]),
        .addr_i    (addr_v[p]),
        .wdata_i   (wdata_v[p][h*HALF_W +: HALF_W]),
        .mem_i     (mem_rd[p][h]),
        .addr_q_o  (addr_q[p][h]),
        .we_o      (we[p][h]),
        .wdata_q_o (wdq[p][h]),
        .rdata_o   (rdq[p][h]),
        .drv_o     (drv_v[p][h])
      );

      assign raddr[h][p]  = addr_q[p][h];
      // stored value folds in the other bank so that XOR of both banks yields the last write
      assign store[p][h]  = wdq[p][h] ^ brd[NUM_PORTS-1-p][h][p];
      assign mem_rd[p][h] = brd[0][h][p] ^ brd[1][h][p];

      dlr_bank #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES_PER_HALF),
        .NRD    (NUM_PORTS)
      ) u_bank (
        .clk_i   (clk_v[p]),
        .we_i    (we[p][h]),
        .waddr_i (addr_q[p][h]),
        .wdata_i (store[p][h]),
        .raddr_i (raddr[h]),
        .rdata_o (brd[p][h])
      );
    end
  end

  assign a_rdata_o = {rdq[0][1], rdq[0][0]};
  assign b_rdata_o = {rdq[1][1], rdq[1][0]};
  assign a_drv_o   = {drv_v[0][1], drv_v[0][0]};
  assign b_drv_o   = {drv_v[1][1], drv_v[1][0]};
endmodule

// File: rtl/dlr_checker.sv
module dlr_checker #(
  parameter int HALF_W = 18
) (
  input logic                  rst_ni,
  input logic                  a_clk_i,
  input logic [1:0]            a_cke_ni,
  input logic [1:0]            a_sel_ni,
  input logic [3:0]            a_wr_ni,
  input logic [1:0]            a_oe_ni,
  input logic [2*HALF_W-1:0]   a_rdata_o,
  input logic [1:0]            a_drv_o,
  input logic                  b_clk_i,
  input logic [1:0]            b_cke_ni,
  input logic [1:0]            b_sel_ni,
  input logic [3:0]            b_wr_ni,
  input logic [1:0]            b_oe_ni,
  input logic [2*HALF_W-1:0]   b_rdata_o,
  input logic [1:0]            b_drv_o
);
  // R1
  p_reset_quiet_a_r1: assert property (@(posedge a_clk_i) !rst_ni |-> a_drv_o == 2'b00);
  p_reset_quiet_b_r1: assert property (@(posedge b_clk_i) !rst_ni |-> b_drv_o == 2'b00);

  for (genvar h = 0; h < 2; h++) begin : g_h
    // R9
    p_drv_needs_oe_a_r9: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
      a_drv_o[h] |-> !a_oe_ni[h]);
    p_drv_needs_oe_b_r9: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
      b_drv_o[h] |-> !b_oe_ni[h]);
    // R5
    p_hold_keeps_a_r5: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
      (a_cke_ni[h] && $past(a_cke_ni[h])) |=> $stable(a_rdata_o[h*HALF_W +: HALF_W]));
    p_hold_keeps_b_r5: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
      (b_cke_ni[h] && $past(b_cke_ni[h])) |=> $stable(b_rdata_o[h*HALF_W +: HALF_W]));
    // R6
    p_desel_drops_a_r6: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
      (!a_cke_ni[h] && a_sel_ni[h]) |=> ##1 !a_drv_o[h]);
    p_desel_drops_b_r6: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
      (!b_cke_ni[h] && b_sel_ni[h]) |=> ##1 !b_drv_o[h]);
    // R7
    p_write_drops_a_r7: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
      (!a_cke_ni[h] && !a_sel_ni[h] && a_wr_ni[2*h +: 2] != 2'b11) |=> ##1 !a_drv_o[h]);
    p_write_drops_b_r7: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
      (!b_cke_ni[h] && !b_sel_ni[h] && b_wr_ni[2*h +: 2] != 2'b11) |=> ##1 !b_drv_o[h]);
    // R8
    p_read_drives_a_r8: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
      (!a_cke_ni[h] && !a_sel_ni[h] && a_wr_ni[2*h +: 2] == 2'b11) |=> ##1 (a_drv_o[h] || a_oe_ni[h]));
    p_read_drives_b_r8: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
      (!b_cke_ni[h] && !b_sel_ni[h] && b_wr_ni[2*h +: 2] == 2'b11) |=> ##1 (b_drv_o[h] || b_oe_ni[h]));
  end
endmodule

bind dual_lane_ram dlr_checker #(.HALF_W(HALF_W)) i_dlr_checker (
  .rst_ni    (rst_ni),
  .a_clk_i   (a_clk_i),
  .a_cke_ni  (a_cke_ni),
  .a_sel_ni  (a_sel_ni),
  .a_wr_ni   (a_wr_ni),
  .a_oe_ni   (a_oe_ni),
  .a_rdata_o (a_rdata_o),
  .a_drv_o   (a_drv_o),
  .b_clk_i   (b_clk_i),
  .b_cke_ni  (b_cke_ni),
  .b_sel_ni  (b_sel_ni),
  .b_wr_ni   (b_wr_ni),
  .b_oe_ni   (b_oe_ni),
  .b_rdata_o (b_rdata_o),
  .b_drv_o   (b_drv_o)
);

// File: tb/test_dual_lane_ram.sv
`timescale 1ns/1ps
module test_dual_lane_ram;
  logic        clk_a = 1'b0;
  logic        clk_b = 1'b0;
  logic        rst_n;
  logic [1:0]  cke  [2];
  logic [1:0]  sel  [2];
  logic [1:0]  oe   [2];
  logic [3:0]  wr   [2];
  logic [11:0] addr [2];
  logic [35:0] wd   [2];
  logic [35:0] rdo  [2];
  logic [1:0]  drv  [2];

  int checks = 0;
  int fails  = 0;
  int cyc_a  = 0;
  int cyc_b  = 0;

  typedef struct {
    int          due;
    logic [35:0] data;
    logic [1:0]  act;
    string       tag;
  } item_t;

  item_t       qa[$];
  item_t       qb[$];
  logic [35:0] ref_mem [4096];
  logic [35:0] exp_data [2];
  logic [1:0]  exp_act  [2];

  always #5 clk_a = ~clk_a;
  initial begin
    #3;
    forever #5 clk_b = ~clk_b;
  end

  dual_lane_ram i_dual_lane_ram (
    .rst_ni    (rst_n),
    .a_clk_i   (clk_a),
    .a_cke_ni  (cke[0]),
    .a_sel_ni  (sel[0]),
    .a_wr_ni   (wr[0]),
    .a_oe_ni   (oe[0]),
    .a_addr_i  (addr[0]),
    .a_wdata_i (wd[0]),
    .a_rdata_o (rdo[0]),
    .a_drv_o   (drv[0]),
    .b_clk_i   (clk_b),
    .b_cke_ni  (cke[1]),
    .b_sel_ni  (sel[1]),
    .b_wr_ni   (wr[1]),
    .b_oe_ni   (oe[1]),
    .b_addr_i  (addr[1]),
    .b_wdata_i (wd[1]),
    .b_rdata_o (rdo[1]),
    .b_drv_o   (drv[1])
  );

  always @(posedge clk_a) if (rst_n) cyc_a = cyc_a + 1;
  always @(posedge clk_b) if (rst_n) cyc_b = cyc_b + 1;

  function automatic int cyc_of(input int p);
    return (p == 0) ? cyc_a : cyc_b;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one command per clock of port p, expected output state queued for its execution edge
  task automatic drive(input int p, input logic [1:0] ck, input logic [1:0] s, input logic [3:0] w,
                       input logic [1:0] o, input logic [11:0] ad, input logic [35:0] d, input string tag);
    item_t it;
    if (p == 0) @(negedge clk_a); else @(negedge clk_b);
    #1;
    cke[p] = ck; sel[p] = s; wr[p] = w; oe[p] = o; addr[p] = ad; wd[p] = d;
    for (int h = 0; h < 2; h++) begin
      if (!ck[h]) begin
        if (s[h]) exp_act[p][h] = 1'b0;
        else if (w[2*h +: 2] != 2'b11) begin
          for (int l = 2*h; l < 2*h + 2; l++)
            if (!w[l]) ref_mem[ad][9*l +: 9] = d[9*l +: 9];
          exp_act[p][h] = 1'b0;
        end else begin
          exp_data[p][18*h +: 18] = ref_mem[ad][18*h +: 18];
          exp_act[p][h] = 1'b1;
        end
      end
    end
    it.due = cyc_of(p) + 2;
    it.data = exp_data[p];
    it.act = exp_act[p];
    it.tag = tag;
    if (p == 0) qa.push_back(it); else qb.push_back(it);
  endtask

  task automatic park(input int p, input string tag);
    drive(p, 2'b11, 2'b11, 4'hF, 2'b00, 12'h000, 36'h0, tag);
  endtask

  task automatic rd(input int p, input logic [11:0] ad, input string tag);
    drive(p, 2'b00, 2'b00, 4'hF, 2'b00, ad, 36'h0, tag);
  endtask

  task automatic wr_full(input int p, input logic [11:0] ad, input logic [35:0] d, input string tag);
    drive(p, 2'b00, 2'b00, 4'h0, 2'b00, ad, d, tag);
  endtask

  // monitor: compares output register and drive enables when a queued command has executed
  task automatic mon(input int p);
    item_t it;
    logic [1:0] dexp;
    while ((p == 0 ? qa.size() : qb.size()) > 0) begin
      it = (p == 0) ? qa[0] : qb[0];
      if (it.due > cyc_of(p)) break;
      if (p == 0) void'(qa.pop_front()); else void'(qb.pop_front());
      dexp = it.act & ~oe[p];
      checks++;
      if (it.due != cyc_of(p) || rdo[p] !== it.data || drv[p] !== dexp) begin
        fails++;
        $display("FAIL %s port=%0d rdata=%h exp=%h drv=%b exp=%b", it.tag, p, rdo[p], it.data, drv[p], dexp);
      end
    end
  endtask

  always @(negedge clk_a) if (rst_n) mon(0);
  always @(negedge clk_b) if (rst_n) mon(1);

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      cke[p] = 2'b11; sel[p] = 2'b11; wr[p] = 4'hF; oe[p] = 2'b00; addr[p] = '0; wd[p] = '0;
      exp_data[p] = '0; exp_act[p] = 2'b00;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk_a);
    #1;
    chk(drv[0] == 2'b00 && drv[1] == 2'b00, "R1 drive during reset", {drv[1], drv[0]}, 0);
    @(negedge clk_a);
    rst_n = 1'b1;
    #1;
    for (int p = 0; p < 2; p++)
      chk(rdo[p] === 36'h0 && drv[p] === 2'b00, "R1 state after reset", {26'h0, drv[p], rdo[p]}, 0);

    // R2 / R8: whole words including address extremes
    wr_full(0, 12'h010, 36'h1_2345_6789, "R2");
    wr_full(0, 12'h011, 36'h9_8765_4321, "R2");
    wr_full(0, 12'h000, 36'hA_AAAA_5555, "R2");
    wr_full(0, 12'hFFF, 36'h5_5555_AAAA, "R2");
    rd(0, 12'hFFF, "R2");
    rd(0, 12'h010, "R8");
    rd(0, 12'h011, "R8");
    rd(0, 12'h000, "R8");

    // R3: single lanes
    drive(0, 2'b00, 2'b00, 4'b1110, 2'b00, 12'h010, 36'hF_FFFF_FFFF, "R3");
    drive(0, 2'b00, 2'b00, 4'b0111, 2'b00, 12'h011, 36'h0_0000_0000, "R3");
    drive(0, 2'b00, 2'b00, 4'b1011, 2'b00, 12'h000, 36'h0_0000_0000, "R3");
    rd(0, 12'h010, "R3");
    rd(0, 12'h011, "R3");
    rd(0, 12'h000, "R3");

    // R4: halves run independently
    drive(0, 2'b10, 2'b00, 4'hF, 2'b00, 12'hFFF, 36'h0, "R4");
    drive(0, 2'b00, 2'b10, 4'hF, 2'b00, 12'h010, 36'h0, "R4");
    drive(0, 2'b00, 2'b00, 4'b0011, 2'b00, 12'h000, 36'h3_FFFF_0000, "R4");
    rd(0, 12'h000, "R4");
    drive(0, 2'b01, 2'b00, 4'hF, 2'b00, 12'h011, 36'h0, "R4");

    // R5: held cycles carrying a write never commit it
    rd(0, 12'h011, "R5");
    repeat (3) drive(0, 2'b11, 2'b00, 4'h0, 2'b00, 12'h010, 36'h0_DEAD_BEEF, "R5");
    rd(0, 12'h010, "R5");

    // R6: deselect with strobes low and high
    drive(0, 2'b00, 2'b11, 4'h0, 2'b00, 12'h010, 36'h0, "R6");
    drive(0, 2'b00, 2'b11, 4'hF, 2'b00, 12'h010, 36'h0, "R6");
    rd(0, 12'h010, "R6");

    // R7: write clears drive, read register holds
    rd(0, 12'h011, "R7");
    wr_full(0, 12'h012, 36'hC_0FFE_E123, "R7");
    park(0, "R7");

    // R10: read, write, read on one address
    rd(0, 12'h012, "R10");
    wr_full(0, 12'h012, 36'h2_4681_3579, "R10");
    rd(0, 12'h012, "R10");
    park(0, "R10");

    // R9: output enable without clock
    rd(0, 12'h012, "R9");
    park(0, "R9");
    park(0, "R9");
    @(negedge clk_a);
    #2;
    oe[0] = 2'b11;
    #1;
    chk(drv[0] === 2'b00, "R9 oe high removes drive", {62'h0, drv[0]}, 0);
    oe[0] = 2'b00;
    #1;
    chk(drv[0] === 2'b11, "R9 oe low restores drive", {62'h0, drv[0]}, 3);
    park(0, "R9");

    // R11: cross-port visibility both directions
    wr_full(0, 12'h200, 36'h0_ABCD_1234, "R11");
    repeat (3) park(0, "R11");
    rd(1, 12'h200, "R11");
    wr_full(1, 12'h300, 36'h7_7777_0001, "R11");
    repeat (3) park(1, "R11");
    rd(0, 12'h300, "R11");
    park(0, "R11");
    park(0, "R11");

    // R12: concurrent streams on both ports
    fork
      begin
        for (int i = 0; i < 8; i++) wr_full(0, 12'h400 + 12'(i), {4'h1, 32'(i * 32'h0101_0101)}, "R12");
        for (int i = 0; i < 8; i++) rd(0, 12'h400 + 12'(i), "R12");
        repeat (3) park(0, "R12");
      end
      begin
        for (int i = 0; i < 8; i++) wr_full(1, 12'h500 + 12'(i), {4'h8, 32'(~(i * 32'h0011_2233))}, "R12");
        for (int i = 0; i < 8; i++) rd(1, 12'h500 + 12'(i), "R12");
        repeat (3) park(1, "R12");
      end
    join

    repeat (3) @(negedge clk_a);
    chk(qa.size() == 0 && qb.size() == 0, "R12 all queued results seen", 64'(qa.size() + qb.size()), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule